// File: doc/BRIEF.md
# Translation Table Base Selector

This block decides, for every virtual address that misses the TLB, which of two translation table bases the table walk should start from. It holds a small control register with a 3-bit boundary field and one walk-disable bit per base. The boundary field splits the 32-bit virtual space. A nonzero value sends addresses whose top bits are all clear to base 0 and every other address to base 1. It also shrinks the base-0 first-level table from 16KB down to 128B. When the walk-disable bit of the chosen base is set, the miss turns into a section translation fault and no walk is requested.

Miss requests arrive on a valid/ready stream. `miss_ready` is low only while reset is held, and it is high from the first clock after reset is released. The block has no downstream back-pressure. An accepted request always produces its result one clock later, as a single-cycle `res_done` pulse together with the base select, the walk or fault flag and the first-level descriptor address. A new request may be accepted on every clock. The control register sits on a plain write strobe and read bus. A write made while the core is secure-privileged and the secure write lock is high is refused, and it raises an undefined-instruction pulse.

Top module: `ttb_sel_top`

## Requirements
- R1: After reset the boundary field is 0 and both walk-disable bits are 0. `cfg_rd_data` reads 0, and `res_done` and `undef_trap` are low.
- R2: The boundary field N is bits [2:0], the base-0 walk disable is bit 4 and the base-1 walk disable is bit 5. Bit 3 and bits [31:6] always read 0, and writes to them have no effect.
- R3: With N = 0, every miss selects base 0 (`res_sel1` = 0).
- R4: With N > 0, a miss selects base 0 when VA[31:32-N] are all zero and selects base 1 otherwise.
- R5: A walk on base 0 has the descriptor address {base0[31:14-N], VA[31-N:20], 2'b00}, which is a table of 16KB >> N bytes.
- R6: A walk on base 1 has the descriptor address {base1[31:14], VA[31:20], 2'b00}.
- R7: When the walk-disable bit of the selected base is 1, the result has `res_fault` = 1, `res_walk` = 0 and a descriptor address of 0. Otherwise it has `res_walk` = 1 and `res_fault` = 0.
- R8: A write with `sec_priv` and `sec_wr_lock` both high leaves the register unchanged and raises `undef_trap` for exactly the next cycle. With either input low, the write is applied.
- R9: `miss_ready` is high from the first cycle after reset. Each accepted request gives exactly one `res_done` pulse on the next cycle, and `res_done` is low in every other cycle.
- R10: A write takes effect at the clock edge of its strobe. A miss accepted in that same cycle uses the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write data |
| cfg_rd_data | output | 32 | Control register read value |
| sec_priv | input | 1 | Core is in secure privileged mode |
| sec_wr_lock | input | 1 | Secure write lock for the control register |
| undef_trap | output | 1 | Pulse: a refused write raises an undefined instruction |
| base0_reg | input | 32 | Table base 0 |
| base1_reg | input | 32 | Table base 1 |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Miss request can be accepted |
| miss_va | input | 32 | Virtual address that missed |
| res_done | output | 1 | Result valid pulse |
| res_sel1 | output | 1 | 1 = base 1 selected |
| res_walk | output | 1 | Walk request issued |
| res_fault | output | 1 | Section translation fault |
| res_desc_addr | output | 32 | First-level descriptor address |

## Verification
A register write and a miss request can land on the same clock edge. The miss must then be judged against the control value from before the write. The bench provokes this by driving the strobe and the request in the same cycle with a new boundary value and walk-disable setting. It picks an address whose selection and fault flag differ between the old value and the new one. The reference model updates its copy of the register only after it has computed the expected result, so a design that forwards the new value fails the base-select or fault comparison.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int ADDR_W   = 32;
  localparam int N_W      = 3;
  localparam int N_CNT    = 1 << N_W;
  localparam int TBL_LOG2 = 14;   // full first-level table: 16KB
  localparam int SEC_LOG2 = 20;   // one descriptor per 1MB section
  localparam int PD0_BIT  = 4;
  localparam int PD1_BIT  = 5;

  typedef struct packed {
    logic           pd1;
    logic           pd0;
    logic [N_W-1:0] n;
  } ttb_ctrl_t;
endpackage

// File: rtl/ttb_ctrl_reg.sv
module ttb_ctrl_reg
  import ttb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              sec_priv,
  input  logic              wr_lock,
  output ttb_ctrl_t         ctrl,
  output logic [ADDR_W-1:0] rd_data,
  output logic              undef_trap
);
  logic      blocked;
  ttb_ctrl_t ctrl_q;

  assign blocked = wr_en && sec_priv && wr_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      undef_trap <= 1'b0;
    end else begin
      undef_trap <= blocked;
      if (wr_en && !blocked) begin
        ctrl_q.n   <= wr_data[N_W-1:0];
        ctrl_q.pd0 <= wr_data[PD0_BIT];
        ctrl_q.pd1 <= wr_data[PD1_BIT];
      end
    end
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rd_data          = '0;
    rd_data[N_W-1:0] = ctrl_q.n;
    rd_data[PD0_BIT] = ctrl_q.pd0;
    rd_data[PD1_BIT] = ctrl_q.pd1;
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[ADDR_W-1:PD1_BIT+1] == '0) && (rd_data[N_W] == 1'b0));

  // R8
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sec_priv && wr_lock) |=> ($stable(rd_data) && undef_trap));
endmodule

// File: rtl/ttb_region_split.sv
module ttb_region_split
  import ttb_pkg::*;
(
  input  ttb_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  output logic              sel1,
  output logic              fault,
  output logic [ADDR_W-1:0] desc
);
  localparam logic [ADDR_W-1:0] ALL1  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LOW2Z = ~(ADDR_W'(3));

  logic [ADDR_W-1:0] va_idx;
  logic [ADDR_W-1:0] cand0 [N_CNT];
  logic              hi_set [N_CNT];
  logic [ADDR_W-1:0] desc0, desc1;

  // VA[31:20] lands on bits [13:2]
  assign va_idx = va >> (SEC_LOG2 - 2);

  for (genvar g = 0; g < N_CNT; g++) begin : g_split
    localparam int SH = TBL_LOG2 - g;
    localparam logic [ADDR_W-1:0] HI_MASK = ALL1 << SH;
    assign cand0[g] = (base0 & HI_MASK) | (va_idx & ~HI_MASK & LOW2Z);
    if (g == 0) begin : g_zero
      assign hi_set[g] = 1'b0;
    end else begin : g_top
      assign hi_set[g] = |va[ADDR_W-1:ADDR_W-g];
    end
  end

  assign desc0 = cand0[ctrl.n];
  assign desc1 = (base1 & (ALL1 << TBL_LOG2)) | (va_idx & ~(ALL1 << TBL_LOG2) & LOW2Z);

  always_comb begin
    sel1  = hi_set[ctrl.n];
    fault = sel1 ? ctrl.pd1 : ctrl.pd0;
    if (fault)     desc = '0;
    else if (sel1) desc = desc1;
    else           desc = desc0;
  end
endmodule

// File: rtl/ttb_result_stage.sv
module ttb_result_stage
  import ttb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sel1,
  input  logic              in_fault,
  input  logic [ADDR_W-1:0] in_desc,
  output logic              done,
  output logic              sel1,
  output logic              walk,
  output logic              fault,
  output logic [ADDR_W-1:0] desc
);
  logic accept;
  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      done     <= 1'b0;
      sel1     <= 1'b0;
      walk     <= 1'b0;
      fault    <= 1'b0;
      desc     <= '0;
    end else begin
      in_ready <= 1'b1;
      done     <= accept;
      if (accept) begin
        sel1  <= in_sel1;
        fault <= in_fault;
        walk  <= !in_fault;
        desc  <= in_desc;
      end
    end
  end

  // R9
  accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done);

  // R7
  fault_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (desc == '0 && !walk));
endmodule

// File: rtl/ttb_sel_top.sv
module ttb_sel_top
  import ttb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  input  logic        sec_priv,
  input  logic        sec_wr_lock,
  output logic        undef_trap,
  input  logic [31:0] base0_reg,
  input  logic [31:0] base1_reg,
  input  logic        miss_valid,
  output logic        miss_ready,
  input  logic [31:0] miss_va,
  output logic        res_done,
  output logic        res_sel1,
  output logic        res_walk,
  output logic        res_fault,
  output logic [31:0] res_desc_addr
);
  ttb_ctrl_t         ctrl;
  logic              sp_sel1, sp_fault;
  logic [ADDR_W-1:0] sp_desc;

  ttb_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .sec_priv   (sec_priv),
    .wr_lock    (sec_wr_lock),
    .ctrl       (ctrl),
    .rd_data    (cfg_rd_data),
    .undef_trap (undef_trap)
  );

  ttb_region_split u_split (
    .ctrl  (ctrl),
    .va    (miss_va),
    .base0 (base0_reg),
    .base1 (base1_reg),
    .sel1  (sp_sel1),
    .fault (sp_fault),
    .desc  (sp_desc)
  );

  ttb_result_stage u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (miss_valid),
    .in_ready (miss_ready),
    .in_sel1  (sp_sel1),
    .in_fault (sp_fault),
    .in_desc  (sp_desc),
    .done     (res_done),
    .sel1     (res_sel1),
    .walk     (res_walk),
    .fault    (res_fault),
    .desc     (res_desc_addr)
  );

  // R3
  n_zero_base0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && cfg_rd_data[N_W-1:0] == '0) |=> !res_sel1);
endmodule

// File: tb/ttb_sel_top_tb.sv
module ttb_sel_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        sec_priv = 1'b0;
  logic        sec_wr_lock = 1'b0;
  logic        undef_trap;
  logic [31:0] base0_reg = 32'hA5C3_7E91;
  logic [31:0] base1_reg = 32'h5B2D_C6F7;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_va = '0;
  logic        res_done, res_sel1, res_walk, res_fault;
  logic [31:0] res_desc_addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ttb_sel_top u_dut (.*);

  // reference model state
  int unsigned m_n = 0;
  bit          m_pd0 = 0, m_pd1 = 0;
  bit          e_done = 0, e_sel = 0, e_fault = 0, e_trap = 0;
  logic [31:0] e_desc = '0;
  int unsigned e_n = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic void ref_calc(input int unsigned n, input bit pd0, input bit pd1,
                                   input logic [31:0] va, input logic [31:0] b0, input logic [31:0] b1,
                                   output bit sel, output bit flt, output logic [31:0] d);
    bit     zero = 1;
    longint size, idx;
    if (n > 0)
      for (int b = 32 - int'(n); b < 32; b++) if (va[b]) zero = 0;
    sel = (n != 0) && !zero;
    flt = sel ? pd1 : pd0;
    if (flt) d = '0;
    else if (!sel) begin
      size = 64'd16384 >> n;
      idx  = (longint'(va) % (64'd1 << (32 - n))) >> 20;
      d = 32'((longint'(b0) / size) * size + idx * 4);
    end else
      d = 32'((longint'(b1) / 16384) * 16384 + (longint'(va) >> 20) * 4);
  endfunction

  always @(posedge clk) begin
    bit s, f; logic [31:0] d;
    if (!rst_n) begin
      m_n = 0; m_pd0 = 0; m_pd1 = 0;
      e_done = 0; e_trap = 0;
    end else begin
      e_done = miss_valid && miss_ready;
      if (e_done) begin
        ref_calc(m_n, m_pd0, m_pd1, miss_va, base0_reg, base1_reg, s, f, d);
        e_sel = s; e_fault = f; e_desc = d; e_n = m_n;
      end
      e_trap = cfg_wr_en && sec_priv && sec_wr_lock;
      if (cfg_wr_en && !e_trap) begin
        m_n = cfg_wr_data[2:0]; m_pd0 = cfg_wr_data[4]; m_pd1 = cfg_wr_data[5];
      end
    end
  end

  // compared on every clock, away from the edge
  always @(negedge clk) begin
    logic [31:0] exp_rd;
    if (rst_n && !finished) begin
      exp_rd = {26'd0, m_pd1, m_pd0, 1'b0, 3'(m_n)};
      check(cfg_rd_data == exp_rd, "R2 readback", cfg_rd_data, exp_rd);
      check(undef_trap == e_trap, "R8 undef_trap", 32'(undef_trap), 32'(e_trap));
      check(res_done == e_done, "R9 res_done", 32'(res_done), 32'(e_done));
      if (e_done && res_done) begin
        check(res_sel1 == e_sel, (e_n == 0) ? "R3 sel" : "R4 sel", 32'(res_sel1), 32'(e_sel));
        check(res_fault == e_fault && res_walk == !e_fault, "R7 fault/walk",
              {res_fault, res_walk}, {e_fault, !e_fault});
        check(res_desc_addr == e_desc, e_sel ? "R6 desc" : "R5 desc", res_desc_addr, e_desc);
      end
    end
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic miss(input logic [31:0] va);
    @(negedge clk);
    miss_valid = 1'b1; miss_va = va;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_rd_data == 32'd0, "R1 rd_data", cfg_rd_data, 32'd0);
    check(!res_done && !undef_trap, "R1 done/trap", {res_done, undef_trap}, 32'd0);
    check(miss_ready == 1'b1, "R9 ready", 32'(miss_ready), 32'd1);
    miss(32'hFFFF_FFFF);
    miss(32'h0000_0000);
    // R2 reserved bits ignored
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    check(cfg_rd_data == 32'h37, "R2 reserved", cfg_rd_data, 32'h37);
    // R3/R4/R5/R6 boundary sweep
    for (int n = 0; n < 8; n++) begin
      wr(32'(n));
      miss(32'h0000_0000);
      miss(32'hFFFF_FFFF);
      miss(32'h1234_5678 ^ 32'(n * 32'h0110_0000));
      if (n > 0) begin
        miss(32'((64'd1 << (32 - n)) - 1));
        miss(32'(64'd1 << (32 - n)));
      end
    end
    // R7 walk disables
    wr(32'h11);
    miss(32'h0010_0000);
    miss(32'hF000_0000);
    wr(32'h21);
    miss(32'h0010_0000);
    miss(32'hF000_0000);
    // back-to-back requests
    @(negedge clk);
    miss_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      miss_va = 32'(i) * 32'h2A70_0000;
      @(negedge clk);
    end
    miss_valid = 1'b0;
    // R8 locked secure write
    wr(32'h02);
    sec_priv = 1'b1; sec_wr_lock = 1'b1;
    wr(32'h35);
    check(cfg_rd_data == 32'h02, "R8 blocked", cfg_rd_data, 32'h02);
    sec_priv = 1'b0;
    wr(32'h05);
    check(cfg_rd_data == 32'h05, "R8 nonsecure write", cfg_rd_data, 32'h05);
    sec_wr_lock = 1'b0;
    // R10 write and miss in the same cycle
    wr(32'h00);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h27;
    miss_valid = 1'b1; miss_va = 32'hC000_0000;
    @(negedge clk);
    cfg_wr_en = 1'b0; miss_valid = 1'b0;
    check(res_sel1 == 1'b0 && res_walk == 1'b1, "R10 old value used", {res_sel1, res_walk}, 32'b01);
    check(cfg_rd_data == 32'h27, "R10 new value", cfg_rd_data, 32'h27);
    miss(32'hC000_0000);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule